// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block turns a three-bit request code from the user logic into the row-strobe, column-strobe and write-enable levels of a DDR SDRAM command bus. It also drives a two-bit select for an external address multiplexer. A plain read or write request opens a row with ACTIVE, waits out the row-to-column delay, issues the column command and then counts the burst. After the burst it closes the bank with PRECHARGE. A refresh request issues one REFRESH and then waits for a fixed number of cycles. An extended request passes a raw address to the memory for a mode-register write or a precharge, and then raises a done flag for as long as the request stays up.

Each access opens one row only, and the bank address is driven elsewhere. The datapath gets a write enable and a read enable that are high from the column command to the end of the burst. Every registered output is a field of the state register, so no output needs a decoder.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, the strobes {ras_n,cas_n,we_n} read 111 (NOP), addr_sel reads 00, and wr_en, rd_en and done are all low.
- R2: In idle, request code 000 keeps NOP on the strobes. Codes 001 (refresh), 010 (write), 011 (read) and any code with bit 2 set (extended) start an operation in the cycle after they are seen.
- R3: A read or write starts with one ACTIVE cycle (strobes 011, addr_sel 00, enables low). Exactly two NOP cycles follow it before the column command.
- R4: The column command is WRITE (100) with wr_en high for a write, or READ (101) with rd_en high for a read. In both cases addr_sel is 01 for one cycle.
- R5: After the column command come burst-wait cycles with NOP strobes and the same enable held high. Their number is half the burst length: bl_code 001 gives 1 cycle, 010 gives 2 and 011 gives 4. Every other bl_code value gives 1 cycle.
- R6: After the last burst-wait cycle there is one PRECHARGE cycle (010, addr_sel 00, enables low), and then the block is idle.
- R7: Refresh drives REFRESH (001) for one cycle, then REF_CYC NOP cycles (5 by default), then returns to idle.
- R8: An extended request lasts one cycle with addr_sel 11. Bit 0 of the code selects the strobes: 0 gives mode-register set (000) and 1 gives PRECHARGE (010).
- R9: After an extended request, done stays high with NOP strobes while request bit 2 stays high. It falls in the cycle after bit 2 is seen low, and the block returns to idle.
- R10: A request code presented while an operation is in progress has no effect on that operation's command sequence.
- R11: wr_en and rd_en are never high together, and done is high only with NOP strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd | input | 3 | Request code, sampled only in idle (bit 2 also watched while done) |
| bl_code | input | 3 | Burst length code, sampled at the column command |
| ras_n | output | 1 | Row strobe level, active low |
| cas_n | output | 1 | Column strobe level, active low |
| we_n | output | 1 | Write enable level, active low |
| addr_sel | output | 2 | Address source: 00 row, 01 column, 11 raw user address |
| wr_en | output | 1 | Write datapath enable, column command through end of burst |
| rd_en | output | 1 | Read datapath enable, column command through end of burst |
| done | output | 1 | Extended request finished, held while request bit 2 stays high |

## Verification
The properties on the extended-done handshake assume that the request code only changes in a way the user logic would use. Bit 2 stays high for as long as done is wanted, and a new code is presented only when the block should start it. The other properties assume only that the code is a defined value at each clock edge. The bench changes the code only at the falling edge, so every value is stable at the rising edge. It returns the code to 000 before the block comes back to idle, unless a back-to-back request is intended. While an access is running it deliberately holds conflicting codes, to show that they are ignored.

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq #(
  parameter int REF_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd,
  input  logic [2:0] bl_code,
  output logic       ras_n,
  output logic       cas_n,
  output logic       we_n,
  output logic [1:0] addr_sel,
  output logic       wr_en,
  output logic       rd_en,
  output logic       done
);

  localparam int MAXC  = (REF_CYC > 4) ? REF_CYC : 4;
  localparam int CNT_W = $clog2(MAXC);

  // {spare[2:0], done, wr_en, rd_en, addr_sel[1:0], ras_n, cas_n, we_n}
  localparam logic [10:0] S_IDLE  = 11'b000_0_0_0_00_111;
  localparam logic [10:0] S_REF   = 11'b000_0_0_0_00_001;
  localparam logic [10:0] S_REFW  = 11'b001_0_0_0_00_111;
  localparam logic [10:0] S_WACT  = 11'b000_0_0_0_00_011;
  localparam logic [10:0] S_RACT  = 11'b001_0_0_0_00_011;
  localparam logic [10:0] S_WN1   = 11'b010_0_0_0_00_111;
  localparam logic [10:0] S_WN2   = 11'b011_0_0_0_00_111;
  localparam logic [10:0] S_RN1   = 11'b100_0_0_0_00_111;
  localparam logic [10:0] S_RN2   = 11'b101_0_0_0_00_111;
  localparam logic [10:0] S_WCOL  = 11'b000_0_1_0_01_100;
  localparam logic [10:0] S_RCOL  = 11'b000_0_0_1_01_101;
  localparam logic [10:0] S_WBST  = 11'b000_0_1_0_00_111;
  localparam logic [10:0] S_RBST  = 11'b000_0_0_1_00_111;
  localparam logic [10:0] S_TERM  = 11'b000_0_0_0_00_010;
  localparam logic [10:0] S_XMRS  = 11'b000_0_0_0_11_000;
  localparam logic [10:0] S_XPRE  = 11'b000_0_0_0_11_010;
  localparam logic [10:0] S_XDONE = 11'b000_1_0_0_00_111;

  logic [10:0]      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_m1;

  always_comb begin
    case (bl_code)
      3'b010:  half_m1 = CNT_W'(1);
      3'b011:  half_m1 = CNT_W'(3);
      default: half_m1 = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      S_IDLE: begin
        if (cmd[2])            state_d = cmd[0] ? S_XPRE : S_XMRS;
        else if (cmd == 3'b001) state_d = S_REF;
        else if (cmd == 3'b010) state_d = S_WACT;
        else if (cmd == 3'b011) state_d = S_RACT;
      end
      S_REF: begin
        state_d = S_REFW;
        cnt_d   = CNT_W'(REF_CYC - 1);
      end
      S_REFW: begin
        if (cnt_q == '0) state_d = S_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      S_WACT: state_d = S_WN1;
      S_WN1:  state_d = S_WN2;
      S_WN2:  state_d = S_WCOL;
      S_RACT: state_d = S_RN1;
      S_RN1:  state_d = S_RN2;
      S_RN2:  state_d = S_RCOL;
      S_WCOL: begin
        state_d = S_WBST;
        cnt_d   = half_m1;
      end
      S_RCOL: begin
        state_d = S_RBST;
        cnt_d   = half_m1;
      end
      S_WBST, S_RBST: begin
        if (cnt_q == '0) state_d = S_TERM;
        else             cnt_d   = cnt_q - 1'b1;
      end
      S_TERM:         state_d = S_IDLE;
      S_XMRS, S_XPRE: state_d = S_XDONE;
      S_XDONE:        if (!cmd[2]) state_d = S_IDLE;
      default:        state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign {ras_n, cas_n, we_n} = state_q[2:0];
  assign addr_sel             = state_q[4:3];
  assign rd_en                = state_q[5];
  assign wr_en                = state_q[6];
  assign done                 = state_q[7];

endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cmd,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] addr_sel,
  input logic       wr_en,
  input logic       rd_en,
  input logic       done
);

  logic [2:0] strb;
  assign strb = {ras_n, cas_n, we_n};

  p_act_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb == 3'b011) |=> (strb == 3'b111) ##1 (strb == 3'b111)
                         ##1 (strb == 3'b100 || strb == 3'b101));

  p_col_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb == 3'b100 || strb == 3'b101) |-> (addr_sel == 2'b01));

  p_wr_col_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb == 3'b100) |-> (wr_en && !rd_en));

  p_term_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb == 3'b010 && addr_sel == 2'b00)
      |=> (strb == 3'b111 && !wr_en && !rd_en && !done));

  p_ref_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb == 3'b001) |=> (strb == 3'b111 && !wr_en && !rd_en));

  p_raw_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_sel == 2'b11) |-> (strb == 3'b000 || strb == 3'b010) ##1 done);

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd[2]) |=> done);

  p_done_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd[2]) |=> !done);

  p_en_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en) && (!done || strb == 3'b111));

endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr_sel(addr_sel), .wr_en(wr_en), .rd_en(rd_en), .done(done)
);

// File: tb/ddr_cmd_seq_tb.sv
module ddr_cmd_seq_tb_top;
  localparam int REF_CYC = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = 3'b000;
  logic [2:0] bl_code = 3'b001;
  logic       ras_n, cas_n, we_n, wr_en, rd_en, done;
  logic [1:0] addr_sel;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ddr_cmd_seq #(.REF_CYC(REF_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bl_code(bl_code),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr_sel(addr_sel),
    .wr_en(wr_en), .rd_en(rd_en), .done(done)
  );

  function automatic logic [8:0] mk(logic [2:0] s, logic [1:0] sel,
                                    logic w, logic r, logic d);
    return {s, sel, w, r, d};
  endfunction

  localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, WRC = 3'b100,
                         RDC = 3'b101, REF = 3'b001, PRE = 3'b010, MRS = 3'b000;

  task automatic chk(string req, logic [8:0] exp);
    logic [8:0] act;
    act = {ras_n, cas_n, we_n, addr_sel, wr_en, rd_en, done};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Issues a read or write with the given burst code; noise is held on cmd while busy.
  task automatic access(bit is_rd, logic [2:0] blc, logic [2:0] noise);
    int half;
    half = (blc == 3'b010) ? 2 : (blc == 3'b011) ? 4 : 1;
    @(negedge clk); cmd = is_rd ? 3'b011 : 3'b010; bl_code = blc;
    @(negedge clk); cmd = noise;
    chk("R3 active", mk(ACT, 2'b00, 0, 0, 0));
    @(negedge clk); chk("R3 nop1", mk(NOP, 2'b00, 0, 0, 0));
    @(negedge clk); chk("R3 nop2", mk(NOP, 2'b00, 0, 0, 0));
    @(negedge clk);
    chk("R4 column", mk(is_rd ? RDC : WRC, 2'b01, !is_rd, is_rd, 0));
    for (int i = 0; i < half; i++) begin
      @(negedge clk); chk("R5 burst wait", mk(NOP, 2'b00, !is_rd, is_rd, 0));
    end
    @(negedge clk); cmd = 3'b000;
    chk("R6 precharge R10", mk(PRE, 2'b00, 0, 0, 0));
    @(negedge clk); chk("R6 idle", mk(NOP, 2'b00, 0, 0, 0));
  endtask

  task automatic refresh(logic [2:0] noise);
    @(negedge clk); cmd = 3'b001;
    @(negedge clk); cmd = noise;
    chk("R7 refresh", mk(REF, 2'b00, 0, 0, 0));
    for (int i = 0; i < REF_CYC; i++) begin
      @(negedge clk);
      if (i == REF_CYC - 1) cmd = 3'b000;
      chk("R7 wait R10", mk(NOP, 2'b00, 0, 0, 0));
    end
    @(negedge clk); chk("R7 idle", mk(NOP, 2'b00, 0, 0, 0));
  endtask

  task automatic extended(logic [2:0] c, int hold);
    @(negedge clk); cmd = c;
    @(negedge clk); chk("R8 extended", mk(c[0] ? PRE : MRS, 2'b11, 0, 0, 0));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (i == hold - 1) cmd = 3'b000;
      chk("R9 done held", mk(NOP, 2'b00, 0, 0, 1));
    end
    @(negedge clk); chk("R9 done cleared", mk(NOP, 2'b00, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", mk(NOP, 2'b00, 0, 0, 0));
    rst_n = 1'b1;
    @(negedge clk); chk("R1 after reset", mk(NOP, 2'b00, 0, 0, 0));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R2 code 000 idle", mk(NOP, 2'b00, 0, 0, 0));
    end
    for (int b = 0; b < 8; b++) begin
      access(1'b0, 3'(b), 3'b000);
      access(1'b1, 3'(b), 3'b000);
    end
    access(1'b0, 3'b011, 3'b011);
    access(1'b1, 3'b010, 3'b101);
    access(1'b1, 3'b001, 3'b001);
    refresh(3'b000);
    refresh(3'b010);
    for (int c = 4; c < 8; c++)
      for (int h = 1; h <= 3; h++) extended(3'(c), h);
    // reset in the middle of a burst
    @(negedge clk); cmd = 3'b010; bl_code = 3'b011;
    @(negedge clk); cmd = 3'b000;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk); chk("R1 reset mid access", mk(NOP, 2'b00, 0, 0, 0));
    rst_n = 1'b1;
    access(1'b1, 3'b011, 3'b000);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule